// File: doc/BRIEF.md
# Audio Subframe Word Formatter

This block turns one multichannel frame of raw LPCM samples into a bus of 32-bit per-channel audio words, one word per channel, with channel n in bits [32n+31:32n] of the output. Each word carries the sample left-justified in its low 24 bits, followed by the per-channel validity, user and channel-status flags, a parity bit, a two-bit preamble code, a reserved bit and a sample-present flag. A downstream packetizer consumes the valid-qualified word bus and handles link symbols and line coding.

The audio clock may run faster than the true sample rate, so each frame is qualified by `in_valid`. Where the two clocks match, `in_valid` can simply be held high. Channels are taken in pairs: an even-index channel is subframe 1 and an odd-index channel is subframe 2. A two-state sequencer (states `SEQ_BLOCK_HEAD` and `SEQ_BLOCK_BODY`) with a frame counter tracks the position in an audio block of `BLOCK_FRAMES` frames, so that subframe 1 of the first frame in each block carries the block-start preamble. Its transitions are: reset to `SEQ_BLOCK_HEAD` from any state; `enter_body` from HEAD to BODY on an accepted frame; `count` from BODY to BODY on an accepted frame below the last; `wrap` from BODY to HEAD on the accepted frame at the last count. When no frame is accepted, the state holds.

In single-channel mode, channel 1 (the second word of the first pair) is filled with a padding word. That word carries only the shared sample-present flag.

Top module: `afmt_subframe_fmt`

## Requirements
- R1: Bits 23:0 of each word hold that channel's sample left-justified, with the sample MSB at bit 23 and the low 24-SAMPLE_W bits zero.
- R2: Bit 24 is that channel's validity input, bit 25 its user input and bit 26 its channel-status input.
- R3: Bits 29:28 hold the preamble code. For an even-index channel it is 2'b00 on the block-start frame and 2'b01 on every other frame. For an odd-index channel it is always 2'b10.
- R4: Bit 30 of every word is always 0.
- R5: Bit 31 of every word in a frame equals the shared `in_present` input of that frame.
- R6: A frame presented with `in_valid` high at a clock edge appears on `out_words`, with `out_valid` high, in the following cycle. After an edge with `in_valid` low, `out_valid` is low and `out_words` keeps its previous value.
- R7: When `in_single` is high, the word for channel 1 is `{in_present, 31'b0}` whatever that channel's sample and flag inputs are.
- R8: Bit 27 is set so that bits 27:0 of the word hold an even number of ones.
- R9: Frames are counted only when accepted. The first accepted frame of each block is the block start, and the block start recurs every BLOCK_FRAMES accepted frames (192 by default).
- R10: While the synchronous, active-high `rst` is asserted, `out_valid` and `out_words` are driven to zero. The first frame accepted after reset is a block start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the input frame on this cycle |
| in_samples | input | NUM_CH*SAMPLE_W | Raw samples, channel n at [n*SAMPLE_W +: SAMPLE_W] |
| in_v | input | NUM_CH | Per-channel validity flag |
| in_u | input | NUM_CH | Per-channel user bit |
| in_c | input | NUM_CH | Per-channel channel-status bit |
| in_present | input | 1 | Shared sample-present flag for the frame |
| in_single | input | 1 | Single-channel mode: channel 1 becomes a padding word |
| out_valid | output | 1 | Output frame valid |
| out_words | output | NUM_CH*32 | Formatted words, channel n at [32n+31:32n] |

## Verification
The hardest situation to reach is the block wrap while input frames arrive with gaps. The counter must advance only on accepted frames, so the block-start preamble has to recur after exactly 192 accepted frames and not after 192 clock cycles. The stimulus therefore runs more than two full blocks with `in_valid` randomly dropped for many cycles. It then asserts reset partway through a block and confirms that the next accepted frame is a block start. Full-scale and all-zero samples are mixed in to expose the zero-fill and parity edges.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

    localparam int WORD_W     = 32;
    localparam int SLOT_W     = 24;
    localparam int BIT_V      = 24;
    localparam int BIT_U      = 25;
    localparam int BIT_C      = 26;
    localparam int BIT_PAR    = 27;
    localparam int BIT_PRE_LO = 28;
    localparam int BIT_RSVD   = 30;
    localparam int BIT_SP     = 31;

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'b00,
        PRE_SUB1  = 2'b01,
        PRE_SUB2  = 2'b10
    } preamble_t;

    typedef enum logic [0:0] {
        SEQ_BLOCK_HEAD = 1'b0,
        SEQ_BLOCK_BODY = 1'b1
    } seq_state_t;

endpackage

// File: rtl/afmt_frame_seq.sv
module afmt_frame_seq
    import afmt_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic blk_start
);

    localparam int CNT_W = (BLOCK_FRAMES > 2) ? $clog2(BLOCK_FRAMES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_FRAMES - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (adv) begin
            unique case (state_q)
                SEQ_BLOCK_HEAD: begin      // enter_body
                    state_d = SEQ_BLOCK_BODY;
                    cnt_d   = CNT_W'(1);
                end
                SEQ_BLOCK_BODY: begin
                    if (cnt_q == LAST) begin   // wrap
                        state_d = SEQ_BLOCK_HEAD;
                        cnt_d   = '0;
                    end else begin             // count
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = SEQ_BLOCK_HEAD;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_BLOCK_HEAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SEQ_BLOCK_HEAD: blk_start = 1'b1;
            SEQ_BLOCK_BODY: blk_start = 1'b0;
            default:        blk_start = 1'b0;
        endcase
    end

endmodule

// File: rtl/afmt_chan_pack.sv
module afmt_chan_pack
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter bit IS_SUB2  = 1'b0
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                v,
    input  logic                u,
    input  logic                c,
    input  logic                present,
    input  logic                blk_start,
    input  logic                force_pad,
    output logic [WORD_W-1:0]   word
);

    localparam int SHIFT = SLOT_W - SAMPLE_W;

    logic [SLOT_W-1:0] slot;
    preamble_t         pre;

    always_comb slot = SLOT_W'(sample) << SHIFT;

    generate
        if (IS_SUB2) begin : g_sub2
            always_comb pre = blk_start ? PRE_SUB2 : PRE_SUB2;
        end else begin : g_sub1
            always_comb pre = blk_start ? PRE_BLOCK : PRE_SUB1;
        end
    endgenerate

    always_comb begin
        word = '0;
        if (force_pad) begin
            word[BIT_SP] = present;
        end else begin
            word[SLOT_W-1:0]               = slot;
            word[BIT_V]                    = v;
            word[BIT_U]                    = u;
            word[BIT_C]                    = c;
            word[BIT_PAR]                  = ^{c, u, v, slot};
            word[BIT_PRE_LO+1:BIT_PRE_LO]  = pre;
            word[BIT_RSVD]                 = 1'b0;
            word[BIT_SP]                   = present;
        end
    end

endmodule

// File: rtl/afmt_subframe_fmt.sv
module afmt_subframe_fmt
    import afmt_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int SAMPLE_W     = 20,
    parameter int BLOCK_FRAMES = 192
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] in_samples,
    input  logic [NUM_CH-1:0]          in_v,
    input  logic [NUM_CH-1:0]          in_u,
    input  logic [NUM_CH-1:0]          in_c,
    input  logic                       in_present,
    input  logic                       in_single,
    output logic                       out_valid,
    output logic [NUM_CH*WORD_W-1:0]   out_words
);

    localparam int BUS_W = NUM_CH * WORD_W;

    logic             head;
    logic [BUS_W-1:0] packed_w;

    afmt_frame_seq #(
        .BLOCK_FRAMES(BLOCK_FRAMES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .adv       (in_valid),
        .blk_start (head)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            logic pad;
            if (ch == 1) begin : g_pad
                assign pad = in_single;
            end else begin : g_nopad
                assign pad = 1'b0;
            end

            afmt_chan_pack #(
                .SAMPLE_W (SAMPLE_W),
                .IS_SUB2  (ch % 2 == 1)
            ) u_pack (
                .sample    (in_samples[ch*SAMPLE_W +: SAMPLE_W]),
                .v         (in_v[ch]),
                .u         (in_u[ch]),
                .c         (in_c[ch]),
                .present   (in_present),
                .blk_start (head),
                .force_pad (pad),
                .word      (packed_w[ch*WORD_W +: WORD_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_words <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_words <= packed_w;
            end
        end
    end

endmodule

// File: rtl/afmt_subframe_chk.sv
module afmt_subframe_chk #(
    parameter int NUM_CH       = 8,
    parameter int BLOCK_FRAMES = 192
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  out_valid,
    input logic [NUM_CH*32-1:0]  out_words
);

    int unsigned blk_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_cnt <= 0;
        end else if (out_valid) begin
            blk_cnt <= (blk_cnt == BLOCK_FRAMES - 1) ? 0 : blk_cnt + 1;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                 // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_words)));       // R6
    AST_BLOCK_HEAD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && blk_cnt == 0) |-> out_words[29:28] == 2'b00);  // R9
    AST_BLOCK_BODY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && blk_cnt != 0) |-> out_words[29:28] == 2'b01);  // R3

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_word
            AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> !out_words[32*g+30]);              // R4
            AST_SP_SHARED: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> out_words[32*g+31] == out_words[31]);  // R5
            AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> !(^out_words[32*g +: 28]));        // R8
            if (g % 2 == 1) begin : g_sub2
                AST_SUB2_CODE: assert property (@(posedge clk) disable iff (rst)
                    (out_valid && out_words[32*g +: 31] != 31'd0)
                        |-> out_words[32*g+29 -: 2] == 2'b10);   // R3
            end
        end
    endgenerate

endmodule

bind afmt_subframe_fmt afmt_subframe_chk #(
    .NUM_CH       (NUM_CH),
    .BLOCK_FRAMES (BLOCK_FRAMES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_words (out_words)
);

// File: tb/afmt_subframe_fmt_tb_top.sv
module afmt_subframe_fmt_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam int SAMPLE_W   = 20;
    localparam int BLK        = 192;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       in_valid = 1'b0;
    logic [NUM_CH*SAMPLE_W-1:0] in_samples = '0;
    logic [NUM_CH-1:0]          in_v = '0, in_u = '0, in_c = '0;
    logic                       in_present = 1'b0;
    logic                       in_single = 1'b0;
    logic                       out_valid;
    logic [NUM_CH*32-1:0]       out_words;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    afmt_subframe_fmt #(
        .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .BLOCK_FRAMES(BLK)
    ) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
        .in_v(in_v), .in_u(in_u), .in_c(in_c), .in_present(in_present),
        .in_single(in_single), .out_valid(out_valid), .out_words(out_words)
    );

    // behavioural reference model
    int              frame_m = 0;
    logic            exp_valid = 1'b0;
    logic [31:0]     exp_w [NUM_CH];
    int              exp_frame = 0;

    initial for (int i = 0; i < NUM_CH; i++) exp_w[i] = '0;

    always @(posedge clk) begin
        if (rst) begin
            frame_m   = 0;
            exp_valid = 1'b0;
            for (int i = 0; i < NUM_CH; i++) exp_w[i] = '0;
        end else if (in_valid) begin
            for (int i = 0; i < NUM_CH; i++) begin
                logic [31:0] w;
                int s;
                w = '0;
                if (in_single && i == 1) begin
                    w[31] = in_present;
                end else begin
                    s = int'(in_samples[i*SAMPLE_W +: SAMPLE_W]);
                    w[23:0] = 24'(s * (1 << (24 - SAMPLE_W)));
                    w[24] = in_v[i];
                    w[25] = in_u[i];
                    w[26] = in_c[i];
                    w[29:28] = (i % 2 == 1) ? 2'd2 : ((frame_m == 0) ? 2'd0 : 2'd1);
                    w[31] = in_present;
                    w[27] = ($countones(w[26:0]) % 2 == 1);
                end
                exp_w[i] = w;
            end
            exp_frame = frame_m;
            frame_m   = (frame_m + 1) % BLK;
            exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic compare();
        chk(out_valid === exp_valid, "R6 out_valid", 32'(out_valid), 32'(exp_valid));
        for (int i = 0; i < NUM_CH; i++) begin
            logic [31:0] a, e;
            a = out_words[32*i +: 32];
            e = exp_w[i];
            chk(a[23:0] === e[23:0], "R1 sample slot", a, e);
            chk(a[26:24] === e[26:24], "R2 V/U/C flags", a, e);
            chk(a[27] === e[27], "R8 parity", a, e);
            chk(a[29:28] === e[29:28], "R3/R9 preamble", a, e);
            chk(a[30] === 1'b0, "R4 reserved", a, e);
            chk(a[31] === e[31], "R5 present", a, e);
            if (in_single && i == 1 && exp_valid)
                chk(a === e, "R7 padding word", a, e);
        end
        if (exp_valid && exp_frame == 0)
            chk(out_words[29:28] === 2'b00, "R9 block start", 32'(out_words[29:28]), 32'd0);
    endtask

    task automatic drive(input int vprob, input bit extreme_cycle);
        in_valid = ($urandom % 100) < vprob;
        for (int i = 0; i < NUM_CH; i++) begin
            if (extreme_cycle)
                in_samples[i*SAMPLE_W +: SAMPLE_W] = (i % 2 == 1) ? '1 : '0;
            else
                in_samples[i*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'($urandom);
        end
        in_v = NUM_CH'($urandom);
        in_u = NUM_CH'($urandom);
        in_c = NUM_CH'($urandom);
    endtask

    task automatic run(input int cycles, input int vprob);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            compare();
            drive(vprob, (k % 37) == 5);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(out_valid === 1'b0, "R10 reset valid", 32'(out_valid), 32'd0);
        chk(out_words === '0, "R10 reset words", out_words[31:0], 32'd0);
        rst = 1'b0;
        in_present = 1'b1;
        drive(100, 1'b0);
        run(420, 100);                 // continuous, > 2 blocks
        in_present = 1'b0;
        run(120, 60);
        in_present = 1'b1;
        run(500, 45);                  // gaps: counter must hold on idle
        in_single = 1'b1;
        run(80, 70);                   // R7 padding
        in_present = 1'b0;
        run(30, 100);
        in_single = 1'b0;
        in_present = 1'b1;
        run(25, 100);
        @(negedge clk);
        compare();
        rst = 1'b1;                    // mid-block reset
        in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 reset valid mid", 32'(out_valid), 32'd0);
        chk(out_words === '0, "R10 reset words mid", out_words[31:0], 32'd0);
        rst = 1'b0;
        drive(100, 1'b0);
        @(negedge clk);
        compare();
        chk(out_words[29:28] === 2'b00, "R10 block start after reset",
            32'(out_words[29:28]), 32'd0);
        drive(100, 1'b0);
        run(30, 100);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R6 actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule